// File: doc/BRIEF.md
# Multi-Source Event Interrupt Aggregator

This block collects interrupt events from one overview source and up to fifteen controller cores and drives a single interrupt line toward the host. Each source owns a free-running event counter that is visible to the host. A source is pending whenever its live counter differs from the value the host last acknowledged. This means that events arriving while the host is servicing a source are never lost, and no clear-on-read side effects are involved.

Masking uses one 32-bit command word with a two-bit command per source. A single write can mask some sources, unmask others and leave the rest untouched, with no read-modify-write. The intended host flow is as follows. The host masks every source it finds pending. It services each one and writes the handled counter value into that source's acknowledge register. It then unmasks everything with one write of 0x55555555. The interrupt line is the registered OR of all pending, unmasked sources.

Top module: `evt_irq_aggregator`

## Requirements
- R1: Source numbering is shared by all interfaces. Source 0 is the overview source and source i+1 is core i. Source s uses event input bit s, mask command bits [2s+1:2s], acknowledge select value s, counter bits [8s+7:8s] and mask_state bit s.
- R2: When mask_wr_en is high, a mask command of 2'b10 in a source's field sets that source's mask_state bit on the next clock edge.
- R3: When mask_wr_en is high, a mask command of 2'b01 in a source's field clears that source's mask_state bit on the next clock edge.
- R4: Mask commands 2'b00 and 2'b11 leave that source's mask bit unchanged. A single write can therefore change some sources and leave others alone.
- R5: A write of 32'h5555_5555 unmasks all 16 sources at once. A write of 32'hAAAA_AAAA masks all 16 sources at once.
- R6: Each source has an 8-bit event counter. It increments by one on every clock edge where its event input bit is high, wraps from 255 to 0, and is visible on evt_count.
- R7: When ack_wr_en is high, ack_wr_data is loaded into the acknowledge register of the source named by ack_wr_sel. A source is pending exactly while its counter differs from its acknowledge register.
- R8: irq is active high and registered. It equals the OR over all sources of (pending AND NOT masked), taken from the state one clock earlier.
- R9: The reset state is as follows: reset is synchronous and active high. After it, every source is masked, every counter and acknowledge value is 0, and irq is 0.
- R10: If exactly 256 events arrive on a source without an acknowledge, its counter wraps back to the acknowledged value, so the source is no longer pending and raises no interrupt.
- R11: Acknowledging a value older than the live counter (events arrived during service) leaves the source pending, so irq stays or comes back high once the source is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | NUM_CORES+1 | One-cycle event strobe per source |
| mask_wr_en | input | 1 | Mask command word write strobe |
| mask_wr_data | input | 32 | Two-bit command per source |
| ack_wr_en | input | 1 | Acknowledge write strobe |
| ack_wr_sel | input | SEL_W | Source index for the acknowledge write |
| ack_wr_data | input | CNT_W | Handled counter value |
| evt_count | output | (NUM_CORES+1)*CNT_W | Live event counters, packed per source |
| mask_state | output | NUM_CORES+1 | Current mask bit per source (1 = masked) |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with NUM_CORES = 15 and CNT_W = 8. This fills all sixteen two-bit fields of the command word, so the all-unmask and all-mask words reach every source and no field is left unused. An 8-bit counter makes the 256-event wrap case reachable in a few hundred cycles. Random mixes of events, command words containing all four codes, and both matching and stale acknowledges are checked every cycle against a bench model of the counters, the mask and the one-cycle-late interrupt.

// File: rtl/eia_pkg.sv
package eia_pkg;

    localparam int unsigned MAX_SRC    = 16;
    localparam int unsigned CMD_W      = 2;
    localparam int unsigned CMD_WORD_W = MAX_SRC * CMD_W;

    typedef enum logic [CMD_W-1:0] {
        CMD_KEEP     = 2'b00,
        CMD_UNMASK   = 2'b01,
        CMD_MASK     = 2'b10,
        CMD_KEEP_ALT = 2'b11
    } mask_cmd_e;

    typedef struct packed {
        logic pending;
        logic masked;
    } src_flag_t;

    function automatic mask_cmd_e cmd_field(input logic [CMD_WORD_W-1:0] word,
                                            input int unsigned idx);
        return mask_cmd_e'(word[idx*CMD_W +: CMD_W]);
    endfunction

    function automatic logic apply_cmd(input logic cur, input mask_cmd_e cmd);
        logic nxt;
        case (cmd)
            CMD_MASK:   nxt = 1'b1;
            CMD_UNMASK: nxt = 1'b0;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

    function automatic logic flag_fires(input src_flag_t f);
        return f.pending && !f.masked;
    endfunction

endpackage

// File: rtl/eia_src_slot.sv
module eia_src_slot #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_i,
    input  logic             ack_we_i,
    input  logic [CNT_W-1:0] ack_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pending_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (evt_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= '0;
        end else if (ack_we_i) begin
            ack_q <= ack_val_i;
        end
    end

    assign cnt_o     = cnt_q;
    assign pending_o = (cnt_q != ack_q);

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        evt_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !evt_i |=> $stable(cnt_q));

    // R7
    ack_load_chk: assert property (@(posedge clk) disable iff (rst)
        ack_we_i |=> (ack_q == $past(ack_val_i)));

    // R7
    ack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack_we_i && !evt_i && !pending_o) |=> !pending_o);

endmodule

// File: rtl/eia_mask_bank.sv
module eia_mask_bank
    import eia_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we_i,
    input  logic [CMD_WORD_W-1:0] word_i,
    output logic [NUM_SRC-1:0]    mask_o
);

    logic [NUM_SRC-1:0] mask_q;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[s] <= 1'b1;
            end else if (we_i) begin
                mask_q[s] <= apply_cmd(mask_q[s], cmd_field(word_i, s));
            end
        end

        // R2
        mask_set_chk: assert property (@(posedge clk) disable iff (rst)
            (we_i && word_i[s*CMD_W +: CMD_W] == 2'b10) |=> mask_q[s]);

        // R3
        mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
            (we_i && word_i[s*CMD_W +: CMD_W] == 2'b01) |=> !mask_q[s]);

        // R4
        mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (!we_i || word_i[s*CMD_W] == word_i[s*CMD_W+1]) |=> $stable(mask_q[s]));
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/eia_irq_combine.sv
module eia_irq_combine
    import eia_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic               irq_o
);

    src_flag_t [NUM_SRC-1:0] flags;
    logic      [NUM_SRC-1:0] fire;
    logic                    irq_q;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
        assign flags[s].pending = pend_i[s];
        assign flags[s].masked  = mask_i[s];
        assign fire[s]          = flag_fires(flags[s]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |fire;
        end
    end

    assign irq_o = irq_q;

    // R8
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (&mask_i) |=> !irq_o);

    // R8
    none_pending_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_i == '0) |=> !irq_o);

endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator
    import eia_pkg::*;
#(
    parameter int unsigned NUM_CORES = 15,
    parameter int unsigned CNT_W     = 8,
    localparam int unsigned NUM_SRC  = NUM_CORES + 1,
    localparam int unsigned SEL_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SRC-1:0]         evt_pulse,
    input  logic                       mask_wr_en,
    input  logic [CMD_WORD_W-1:0]      mask_wr_data,
    input  logic                       ack_wr_en,
    input  logic [SEL_W-1:0]           ack_wr_sel,
    input  logic [CNT_W-1:0]           ack_wr_data,
    output logic [NUM_SRC*CNT_W-1:0]   evt_count,
    output logic [NUM_SRC-1:0]         mask_state,
    output logic                       irq
);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] ack_we;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign ack_we[s] = ack_wr_en && (ack_wr_sel == SEL_W'(s));

        eia_src_slot #(
            .CNT_W (CNT_W)
        ) slot_i (
            .clk       (clk),
            .rst       (rst),
            .evt_i     (evt_pulse[s]),
            .ack_we_i  (ack_we[s]),
            .ack_val_i (ack_wr_data),
            .cnt_o     (evt_count[s*CNT_W +: CNT_W]),
            .pending_o (pend[s])
        );
    end

    eia_mask_bank #(
        .NUM_SRC (NUM_SRC)
    ) mask_i (
        .clk    (clk),
        .rst    (rst),
        .we_i   (mask_wr_en),
        .word_i (mask_wr_data),
        .mask_o (mask_state)
    );

    eia_irq_combine #(
        .NUM_SRC (NUM_SRC)
    ) irq_i (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend),
        .mask_i (mask_state),
        .irq_o  (irq)
    );

    // R1
    one_ack_target_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_we));

    // R5
    unmask_all_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_wr_en && mask_wr_data == 32'h5555_5555) |=> (mask_state == '0));

endmodule

// File: tb/evt_irq_aggregator_tb_top.sv
module evt_irq_aggregator_tb_top;

    localparam int NC   = 15;
    localparam int NS   = NC + 1;
    localparam int CW   = 8;
    localparam int SW   = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NS-1:0]     evt_pulse = '0;
    logic              mask_wr_en = 1'b0;
    logic [31:0]       mask_wr_data = '0;
    logic              ack_wr_en = 1'b0;
    logic [SW-1:0]     ack_wr_sel = '0;
    logic [CW-1:0]     ack_wr_data = '0;
    logic [NS*CW-1:0]  evt_count;
    logic [NS-1:0]     mask_state;
    logic              irq;

    int vectors = 0;
    int fails   = 0;

    logic [CW-1:0] cnt_m  [NS];
    logic [CW-1:0] ack_m  [NS];
    logic [NS-1:0] mask_m;
    logic          irq_m;

    always #5 clk = ~clk;

    evt_irq_aggregator #(.NUM_CORES(NC), .CNT_W(CW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .evt_pulse    (evt_pulse),
        .mask_wr_en   (mask_wr_en),
        .mask_wr_data (mask_wr_data),
        .ack_wr_en    (ack_wr_en),
        .ack_wr_sel   (ack_wr_sel),
        .ack_wr_data  (ack_wr_data),
        .evt_count    (evt_count),
        .mask_state   (mask_state),
        .irq          (irq)
    );

    function automatic logic model_fire();
        logic f = 1'b0;
        for (int s = 0; s < NS; s++)
            if (cnt_m[s] != ack_m[s] && !mask_m[s]) f = 1'b1;
        return f;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int s = 0; s < NS; s++) begin
            check("R6", $sformatf("count[%0d]", s), int'(evt_count[s*CW +: CW]), int'(cnt_m[s]));
            check("R2,R3,R4", $sformatf("mask[%0d]", s), int'(mask_state[s]), int'(mask_m[s]));
        end
        check("R8", "irq", int'(irq), int'(irq_m));
    endtask

    // Inputs are set away from the edge; advance one clock and update the model.
    task automatic cycle();
        logic nxt_irq = model_fire();
        for (int s = 0; s < NS; s++) begin
            if (evt_pulse[s]) cnt_m[s] = cnt_m[s] + 8'd1;
            if (ack_wr_en && int'(ack_wr_sel) == s) ack_m[s] = ack_wr_data;
            if (mask_wr_en) begin
                if (mask_wr_data[2*s +: 2] == 2'b10) mask_m[s] = 1'b1;
                if (mask_wr_data[2*s +: 2] == 2'b01) mask_m[s] = 1'b0;
            end
        end
        irq_m = nxt_irq;
        @(posedge clk);
        #1;
        compare_all();
        evt_pulse  = '0;
        mask_wr_en = 1'b0;
        ack_wr_en  = 1'b0;
    endtask

    task automatic write_mask(input logic [31:0] w);
        mask_wr_en = 1'b1; mask_wr_data = w; cycle();
    endtask

    task automatic write_ack(input int s, input logic [CW-1:0] v);
        ack_wr_en = 1'b1; ack_wr_sel = SW'(s); ack_wr_data = v; cycle();
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h2b7c_19e5));
        for (int s = 0; s < NS; s++) begin cnt_m[s] = '0; ack_m[s] = '0; end
        mask_m = '1;
        irq_m  = 1'b0;

        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R9: reset state
        check("R9", "mask after reset", int'(mask_state), int'({NS{1'b1}}));
        check("R9", "counters after reset", int'(evt_count == '0), 1);
        check("R9", "irq after reset", int'(irq), 0);

        // R1: event on core 2 is source 3; unmask only field 3
        evt_pulse[3] = 1'b1; cycle();
        check("R1", "count of source 3", int'(evt_count[3*CW +: CW]), 1);
        write_mask(32'h0000_0040);
        check("R1", "only source 3 unmasked", int'(mask_state), int'(16'hFFF7));
        cycle();
        check("R8", "irq raised one cycle after unmask", int'(irq), 1);

        // R4: codes 11 and 00 leave fields alone, 10 on field 0 masks it
        write_mask(32'hFFFF_FF32);
        check("R4", "mixed keep codes", int'(mask_state), int'(16'hFFF7));

        // R7: ack with live counter value retires source 3
        write_ack(3, 8'd1);
        cycle();
        check("R7", "irq drops after matching ack", int'(irq), 0);

        // R5: unmask all, then mask all
        write_mask(32'h5555_5555);
        check("R5", "all unmasked", int'(mask_state), 0);
        write_mask(32'hAAAA_AAAA);
        check("R5", "all masked", int'(mask_state), int'(16'hFFFF));
        write_mask(32'h5555_5555);

        // R11: stale ack leaves source pending
        evt_pulse[7] = 1'b1; cycle();
        evt_pulse[7] = 1'b1; cycle();
        write_ack(7, 8'd1);
        cycle();
        check("R11", "irq after stale ack", int'(irq), 1);
        write_ack(7, 8'd2);
        cycle();
        check("R11", "irq after full ack", int'(irq), 0);

        // R10: 256 events with no ack wrap back to the acked value
        for (int k = 0; k < 256; k++) begin evt_pulse[5] = 1'b1; cycle(); end
        cycle();
        check("R10", "counter wrapped to ack", int'(evt_count[5*CW +: CW]), 0);
        check("R10", "no irq after full wrap", int'(irq), 0);

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            for (int s = 0; s < NS; s++) evt_pulse[s] = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 5) == 0) begin
                mask_wr_en   = 1'b1;
                mask_wr_data = $urandom();
            end
            if ($urandom_range(0, 2) == 0) begin
                int s = $urandom_range(0, NS - 1);
                ack_wr_en   = 1'b1;
                ack_wr_sel  = SW'(s);
                ack_wr_data = ($urandom_range(0, 3) == 0) ? CW'($urandom()) : cnt_m[s];
            end
            cycle();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule